// File: doc/BRIEF.md
# Vector Predicated Compare-and-Branch Unit

This block turns a conventional two-operand compare-and-branch into a sequence of per-element comparisons when either operand is flagged as a vector. It folds the per-element outcomes into a bit mask, one bit per element. The block hands that mask back for write-back to a predicate register when a destination predicate is present. It also decides whether the branch should be taken. When neither operand is a vector it behaves as a single ordinary compare.

A request is started with a one-cycle `start_i` that captures the element count, both vector flags, the source predicate mask, the optional destination mask and its presence flag, the zeroing flag and the compare opcode. Operand pairs then arrive one per accepted cycle on `opa_i`/`opb_i` with `elem_valid_i`, and `elem_idx_o` names the element the unit expects next. After the final element is accepted, `done_o` pulses for one cycle. During that pulse, `taken_o`, `mask_o` and `mask_we_o` carry the outcome. The register file and the program-counter update are left to the surrounding pipeline.

Top module: `vcmp_branch_unit`

## Requirements
- R1: When neither vector flag is set, exactly one element is consumed. `taken_o` equals that single compare. `mask_o` is zero and `mask_we_o` is low during the done pulse.
- R2: `op_i` uses the 3-bit branch encoding: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. Codes 010 and 011 make every compare false.
- R3: The result mask is seeded with zero when `dst_exists_i` is low or `zeroing_i` is high. Otherwise it is seeded with `dst_mask_i`.
- R4: For element i whose source predicate bit i is 1, result bit i becomes the compare outcome of that element. This holds with or without zeroing.
- R5: For element i whose predicate bit is 0, result bit i is cleared when zeroing is on and keeps its seeded value otherwise. Bits at positions not below the element count keep their seeded value.
- R6: An operand whose vector flag is clear takes the value it had at element 0 for every element. Later values on that input have no effect.
- R7: In vector mode, `taken_o` is 1 exactly when the whole MAX_VL-bit result equals the source predicate mask. `mask_o` is the result and `mask_we_o` equals the captured `dst_exists_i`.
- R8: The element count is `vl_i` clamped to the range 1..MAX_VL: a value of 0 counts as 1 and values above MAX_VL count as MAX_VL. Exactly that many `elem_valid_i` cycles are consumed, and `elem_idx_o` counts 0 upward.
- R9: `done_o` is a single-cycle pulse in the cycle after the final element is accepted, and `mask_we_o` is never high outside it.
- R10: `start_i` has no effect while `busy_o` is high, including the cycle in which the final element is accepted. `elem_valid_i` has no effect while idle.
- R11: After reset the unit is idle, with `busy_o`, `done_o`, `taken_o`, `mask_we_o` low and `mask_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a request, captures configuration |
| vl_i | input | VL_W | Requested element count |
| src1_vec_i | input | 1 | First operand is a vector |
| src2_vec_i | input | 1 | Second operand is a vector |
| pred_i | input | MAX_VL | Source predicate mask |
| dst_exists_i | input | 1 | A destination predicate register is present |
| dst_mask_i | input | MAX_VL | Current value of the destination predicate |
| zeroing_i | input | 1 | Zeroing mode |
| op_i | input | 3 | Compare opcode |
| elem_valid_i | input | 1 | Operand pair valid this cycle |
| opa_i | input | DATA_W | First operand of the current element |
| opb_i | input | DATA_W | Second operand of the current element |
| busy_o | output | 1 | Request in progress |
| elem_idx_o | output | IDX_W | Index of the element expected next |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Branch decision |
| mask_o | output | MAX_VL | Accumulated result mask |
| mask_we_o | output | 1 | Write the mask back to the destination predicate |

## Verification
The two events that can coincide are the acceptance of the final element, which ends the request and raises the done pulse, and a new `start_i` that is presented in that same cycle. The bench provokes this by raising `start_i` together with the last operand pair. It also raises `start_i` with a different element count in the middle of a request. It judges the result by checking that the outcome matches the first request alone and that `busy_o` is low the cycle after the pulse, so that no second request was launched.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    typedef enum logic [2:0] {
        CMP_EQ   = 3'b000,
        CMP_NE   = 3'b001,
        CMP_RS2  = 3'b010,
        CMP_RS3  = 3'b011,
        CMP_LT   = 3'b100,
        CMP_GE   = 3'b101,
        CMP_LTU  = 3'b110,
        CMP_GEU  = 3'b111
    } cmp_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } unit_state_e;

    // decoded compare control
    typedef struct packed {
        logic legal;
        logic use_lt;
        logic signed_cmp;
        logic negate;
    } cmp_ctl_t;

    function automatic cmp_ctl_t decode_cmp(input cmp_op_e op);
        cmp_ctl_t c;
        c.legal      = 1'b1;
        c.use_lt     = op[2];
        c.signed_cmp = ~op[1];
        c.negate     = op[0];
        if (op == CMP_RS2 || op == CMP_RS3) begin
            c.legal = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/vcmp_elem_cmp.sv
module vcmp_elem_cmp
    import vcmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              first_i,
    input  logic              vec_a_i,
    input  logic              vec_b_i,
    input  cmp_op_e           op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              cmp_ok_o
);

    logic [DATA_W-1:0] hold_a_q;
    logic [DATA_W-1:0] hold_b_q;
    logic [DATA_W-1:0] use_a;
    logic [DATA_W-1:0] use_b;
    cmp_ctl_t          ctl;
    logic              is_eq;
    logic              is_lt;
    logic              raw;

    // scalar operands are frozen at element 0
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_a_q <= '0;
            hold_b_q <= '0;
        end else if (accept_i && first_i) begin
            hold_a_q <= opa_i;
            hold_b_q <= opb_i;
        end
    end

    always_comb begin
        use_a = (vec_a_i || first_i) ? opa_i : hold_a_q;
        use_b = (vec_b_i || first_i) ? opb_i : hold_b_q;
        ctl   = decode_cmp(op_i);
        is_eq = (use_a == use_b);
        if (ctl.signed_cmp) begin
            is_lt = ($signed(use_a) < $signed(use_b));
        end else begin
            is_lt = (use_a < use_b);
        end
        raw      = ctl.use_lt ? is_lt : is_eq;
        cmp_ok_o = ctl.legal && (raw ^ ctl.negate);
    end

endmodule

// File: rtl/vcmp_mask_acc.sv
module vcmp_mask_acc #(
    parameter int MAX_VL = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load_i,
    input  logic [MAX_VL-1:0] seed_i,
    input  logic              accept_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [MAX_VL-1:0] pred_i,
    input  logic              zero_i,
    input  logic              cmp_ok_i,
    output logic [MAX_VL-1:0] mask_next_o
);

    logic [MAX_VL-1:0] mask_q;

    for (genvar b = 0; b < MAX_VL; b++) begin : g_bit
        logic hit;
        assign hit = accept_i && (idx_i == IDX_W'(b));
        always_comb begin
            if (!hit) begin
                mask_next_o[b] = mask_q[b];
            end else if (pred_i[b]) begin
                mask_next_o[b] = cmp_ok_i;
            end else if (zero_i) begin
                mask_next_o[b] = 1'b0;
            end else begin
                mask_next_o[b] = mask_q[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (seed_load_i) begin
            mask_q <= seed_i;
        end else if (accept_i) begin
            mask_q <= mask_next_o;
        end
    end

endmodule

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
    import vcmp_pkg::*;
#(
    parameter int MAX_VL = 8,
    parameter int VL_W   = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic              src1_vec_i,
    input  logic              src2_vec_i,
    input  logic [MAX_VL-1:0] pred_i,
    input  logic              dst_exists_i,
    input  logic              zeroing_i,
    input  logic [2:0]        op_i,
    input  logic              elem_valid_i,
    input  logic              cmp_ok_i,
    input  logic [MAX_VL-1:0] mask_next_i,
    output logic              busy_o,
    output logic              accept_o,
    output logic              first_o,
    output logic              seed_load_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              vec_a_o,
    output logic              vec_b_o,
    output logic [MAX_VL-1:0] pred_o,
    output logic              zero_o,
    output cmp_op_e           op_o,
    output logic              done_o,
    output logic              taken_o,
    output logic [MAX_VL-1:0] mask_o,
    output logic              we_o
);

    localparam logic [VL_W-1:0] MAX_CNT = VL_W'(MAX_VL);

    typedef struct packed {
        logic              vec_a;
        logic              vec_b;
        logic [MAX_VL-1:0] pred;
        logic              dexists;
        logic              zero;
        logic [2:0]        op;
        logic [IDX_W-1:0]  last_idx;
    } cfg_t;

    unit_state_e      state_q;
    cfg_t             cfg_q;
    cfg_t             cfg_d;
    logic [IDX_W-1:0] idx_q;
    logic [VL_W-1:0]  cnt_eff;
    logic             vec_mode;
    logic             is_last;

    always_comb begin
        if (vl_i == '0) begin
            cnt_eff = VL_W'(1);
        end else if (vl_i > MAX_CNT) begin
            cnt_eff = MAX_CNT;
        end else begin
            cnt_eff = vl_i;
        end
        cfg_d.vec_a   = src1_vec_i;
        cfg_d.vec_b   = src2_vec_i;
        cfg_d.pred    = pred_i;
        cfg_d.dexists = dst_exists_i;
        cfg_d.zero    = zeroing_i;
        cfg_d.op      = op_i;
        if (src1_vec_i || src2_vec_i) begin
            cfg_d.last_idx = IDX_W'(cnt_eff - VL_W'(1));
        end else begin
            cfg_d.last_idx = '0;
        end
    end

    assign busy_o      = (state_q == ST_RUN);
    assign seed_load_o = (state_q == ST_IDLE) && start_i;
    assign accept_o    = busy_o && elem_valid_i;
    assign first_o     = (idx_q == '0);
    assign is_last     = (idx_q == cfg_q.last_idx);
    assign vec_mode    = cfg_q.vec_a || cfg_q.vec_b;
    assign idx_o       = idx_q;
    assign vec_a_o     = cfg_q.vec_a;
    assign vec_b_o     = cfg_q.vec_b;
    assign pred_o      = cfg_q.pred;
    assign zero_o      = cfg_q.zero;
    assign op_o        = cmp_op_e'(cfg_q.op);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            idx_q   <= '0;
            done_o  <= 1'b0;
            taken_o <= 1'b0;
            mask_o  <= '0;
            we_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            we_o   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cfg_q   <= cfg_d;
                        idx_q   <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (accept_o) begin
                        if (is_last) begin
                            state_q <= ST_IDLE;
                            idx_q   <= '0;
                            done_o  <= 1'b1;
                            if (vec_mode) begin
                                taken_o <= (mask_next_i == cfg_q.pred);
                                mask_o  <= mask_next_i;
                                we_o    <= cfg_q.dexists;
                            end else begin
                                taken_o <= cmp_ok_i;
                                mask_o  <= '0;
                            end
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vcmp_branch_unit.sv
module vcmp_branch_unit
    import vcmp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MAX_VL = 8,
    parameter int VL_W   = $clog2(MAX_VL + 1),
    parameter int IDX_W  = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic              src1_vec_i,
    input  logic              src2_vec_i,
    input  logic [MAX_VL-1:0] pred_i,
    input  logic              dst_exists_i,
    input  logic [MAX_VL-1:0] dst_mask_i,
    input  logic              zeroing_i,
    input  logic [2:0]        op_i,
    input  logic              elem_valid_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              busy_o,
    output logic [IDX_W-1:0]  elem_idx_o,
    output logic              done_o,
    output logic              taken_o,
    output logic [MAX_VL-1:0] mask_o,
    output logic              mask_we_o
);

    logic              accept;
    logic              first;
    logic              seed_load;
    logic              vec_a;
    logic              vec_b;
    logic [MAX_VL-1:0] pred_q;
    logic              zero_q;
    cmp_op_e           op_q;
    logic              cmp_ok;
    logic [MAX_VL-1:0] mask_next;
    logic [MAX_VL-1:0] seed;

    assign seed = (dst_exists_i && !zeroing_i) ? dst_mask_i : '0;

    vcmp_ctrl #(
        .MAX_VL (MAX_VL),
        .VL_W   (VL_W),
        .IDX_W  (IDX_W)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .vl_i         (vl_i),
        .src1_vec_i   (src1_vec_i),
        .src2_vec_i   (src2_vec_i),
        .pred_i       (pred_i),
        .dst_exists_i (dst_exists_i),
        .zeroing_i    (zeroing_i),
        .op_i         (op_i),
        .elem_valid_i (elem_valid_i),
        .cmp_ok_i     (cmp_ok),
        .mask_next_i  (mask_next),
        .busy_o       (busy_o),
        .accept_o     (accept),
        .first_o      (first),
        .seed_load_o  (seed_load),
        .idx_o        (elem_idx_o),
        .vec_a_o      (vec_a),
        .vec_b_o      (vec_b),
        .pred_o       (pred_q),
        .zero_o       (zero_q),
        .op_o         (op_q),
        .done_o       (done_o),
        .taken_o      (taken_o),
        .mask_o       (mask_o),
        .we_o         (mask_we_o)
    );

    vcmp_elem_cmp #(
        .DATA_W (DATA_W)
    ) cmp_i (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .first_i  (first),
        .vec_a_i  (vec_a),
        .vec_b_i  (vec_b),
        .op_i     (op_q),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .cmp_ok_o (cmp_ok)
    );

    vcmp_mask_acc #(
        .MAX_VL (MAX_VL),
        .IDX_W  (IDX_W)
    ) acc_i (
        .clk         (clk),
        .rst         (rst),
        .seed_load_i (seed_load),
        .seed_i      (seed),
        .accept_i    (accept),
        .idx_i       (elem_idx_o),
        .pred_i      (pred_q),
        .zero_i      (zero_q),
        .cmp_ok_i    (cmp_ok),
        .mask_next_o (mask_next)
    );

endmodule

// File: rtl/vcmp_branch_unit_chk.sv
module vcmp_branch_unit_chk #(
    parameter int MAX_VL = 8,
    parameter int VL_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [VL_W-1:0]   vl_i,
    input logic              src1_vec_i,
    input logic              src2_vec_i,
    input logic [MAX_VL-1:0] pred_i,
    input logic              elem_valid_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              taken_o,
    input logic [MAX_VL-1:0] mask_o,
    input logic              mask_we_o
);

    localparam logic [VL_W:0] MAX_N = (VL_W + 1)'(MAX_VL);

    logic              vec_q;
    logic [MAX_VL-1:0] pred_q;
    logic [VL_W:0]     need_q;
    logic [VL_W:0]     seen_q;
    logic [VL_W:0]     need_d;

    always_comb begin
        if (!(src1_vec_i || src2_vec_i) || vl_i == '0) begin
            need_d = (VL_W + 1)'(1);
        end else if ({1'b0, vl_i} > MAX_N) begin
            need_d = MAX_N;
        end else begin
            need_d = {1'b0, vl_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q  <= 1'b0;
            pred_q <= '0;
            need_q <= '0;
            seen_q <= '0;
        end else if (start_i && !busy_o) begin
            vec_q  <= src1_vec_i || src2_vec_i;
            pred_q <= pred_i;
            need_q <= need_d;
            seen_q <= '0;
        end else if (elem_valid_i && busy_o) begin
            seen_q <= seen_q + (VL_W + 1)'(1);
        end
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_we_in_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        mask_we_o |-> done_o);

    assert_elem_count_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (seen_q == need_q));

    assert_vec_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && vec_q) |-> (taken_o == (mask_o == pred_q)));

    assert_scalar_nowb_R1: assert property (@(posedge clk) disable iff (rst)
        (done_o && !vec_q) |-> (mask_o == '0 && !mask_we_o));

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !elem_valid_i) |=> busy_o);

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> (!busy_o && !done_o));

    assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !done_o && !mask_we_o));

endmodule

bind vcmp_branch_unit vcmp_branch_unit_chk #(
    .MAX_VL (MAX_VL),
    .VL_W   (VL_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .vl_i         (vl_i),
    .src1_vec_i   (src1_vec_i),
    .src2_vec_i   (src2_vec_i),
    .pred_i       (pred_i),
    .elem_valid_i (elem_valid_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .taken_o      (taken_o),
    .mask_o       (mask_o),
    .mask_we_o    (mask_we_o)
);

// File: tb/vcmp_branch_unit_tb.sv
module vcmp_branch_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int MV         = 8;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [3:0]  vl;
        logic        va;
        logic        vb;
        logic [7:0]  pred;
        logic        dex;
        logic [7:0]  dmask;
        logic        zero;
        logic [2:0]  op;
        logic [31:0] a_base;
        logic [31:0] a_step;
        logic [31:0] b_base;
        logic [31:0] b_step;
        logic        gap;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        // R1 R2: scalar equal, later elements would differ
        '{4'd4, 1'b0, 1'b0, 8'h00, 1'b1, 8'h3C, 1'b0, 3'b000, 32'd5, 32'd1, 32'd5, 32'd0, 1'b0},
        // R1 R2: scalar signed less-than with a negative operand
        '{4'd3, 1'b0, 1'b0, 8'hFF, 1'b0, 8'h00, 1'b0, 3'b100, 32'hFFFFFFFD, 32'd0, 32'd2, 32'd0, 1'b0},
        // R4 R7: not-equal across 8 elements, scalar second operand
        '{4'd8, 1'b1, 1'b0, 8'hFF, 1'b1, 8'h00, 1'b0, 3'b001, 32'd0, 32'd1, 32'd3, 32'd0, 1'b0},
        // R5 R6: unsigned less-than, sparse predicate, seed kept, varying scalar input
        '{4'd6, 1'b1, 1'b0, 8'h5A, 1'b1, 8'hA5, 1'b0, 3'b110, 32'd0, 32'd2, 32'd5, 32'd100, 1'b0},
        // R3 R5: zeroing clears masked-out and seed
        '{4'd8, 1'b1, 1'b0, 8'h0F, 1'b1, 8'hFF, 1'b1, 3'b101, 32'd10, 32'hFFFFFFFF, 32'd4, 32'd0, 1'b0},
        // R3 R7: no destination, unsigned greater-or-equal, taken
        '{4'd2, 1'b0, 1'b1, 8'h03, 1'b0, 8'hFF, 1'b0, 3'b111, 32'd9, 32'd0, 32'd1, 32'd1, 1'b0},
        // R8: count above limit clamps to MAX_VL
        '{4'd15, 1'b1, 1'b1, 8'hFF, 1'b1, 8'h00, 1'b1, 3'b000, 32'd7, 32'd3, 32'd7, 32'd3, 1'b0},
        // R8 R2: zero count runs one element, reserved opcode is false
        '{4'd0, 1'b1, 1'b0, 8'h01, 1'b1, 8'h00, 1'b0, 3'b010, 32'd1, 32'd1, 32'd1, 32'd0, 1'b0},
        // R4: signed less-than with idle gaps between elements
        '{4'd8, 1'b1, 1'b1, 8'hF0, 1'b1, 8'h0F, 1'b0, 3'b100, 32'hFFFFFFFC, 32'd1, 32'd0, 32'd0, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_i = 1'b0;
    logic [3:0]      vl_i = '0;
    logic            src1_vec_i = 1'b0;
    logic            src2_vec_i = 1'b0;
    logic [MV-1:0]   pred_i = '0;
    logic            dst_exists_i = 1'b0;
    logic [MV-1:0]   dst_mask_i = '0;
    logic            zeroing_i = 1'b0;
    logic [2:0]      op_i = '0;
    logic            elem_valid_i = 1'b0;
    logic [DW-1:0]   opa_i = '0;
    logic [DW-1:0]   opb_i = '0;
    logic            busy_o;
    logic [2:0]      elem_idx_o;
    logic            done_o;
    logic            taken_o;
    logic [MV-1:0]   mask_o;
    logic            mask_we_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    vcmp_branch_unit #(.DATA_W(DW), .MAX_VL(MV)) dut_i (
        .clk (clk), .rst (rst), .start_i (start_i), .vl_i (vl_i),
        .src1_vec_i (src1_vec_i), .src2_vec_i (src2_vec_i), .pred_i (pred_i),
        .dst_exists_i (dst_exists_i), .dst_mask_i (dst_mask_i),
        .zeroing_i (zeroing_i), .op_i (op_i), .elem_valid_i (elem_valid_i),
        .opa_i (opa_i), .opb_i (opb_i), .busy_o (busy_o),
        .elem_idx_o (elem_idx_o), .done_o (done_o), .taken_o (taken_o),
        .mask_o (mask_o), .mask_we_o (mask_we_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_cmp(input logic [2:0] op, input logic [31:0] a,
                                   input logic [31:0] b);
        case (op)
            3'b000:  return a == b;
            3'b001:  return a != b;
            3'b100:  return $signed(a) < $signed(b);
            3'b101:  return $signed(a) >= $signed(b);
            3'b110:  return a < b;
            3'b111:  return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int eff_count(input vec_t v);
        if (!(v.va || v.vb)) return 1;
        if (v.vl == 0) return 1;
        if (v.vl > MV) return MV;
        return int'(v.vl);
    endfunction

    function automatic logic [31:0] elem_a(input vec_t v, input int i);
        return v.a_base + v.a_step * 32'(i);
    endfunction

    function automatic logic [31:0] elem_b(input vec_t v, input int i);
        return v.b_base + v.b_step * 32'(i);
    endfunction

    task automatic apply_cfg(input vec_t v);
        vl_i         = v.vl;
        src1_vec_i   = v.va;
        src2_vec_i   = v.vb;
        pred_i       = v.pred;
        dst_exists_i = v.dex;
        dst_mask_i   = v.dmask;
        zeroing_i    = v.zero;
        op_i         = v.op;
    endtask

    // mode: 0 plain, 1 restart attempt mid-run, 2 start with last element
    task automatic run_vec(input vec_t v, input int mode);
        int          n;
        bit          vec;
        logic [7:0]  em;
        bit          et;
        bit          ew;
        logic [31:0] a0;
        logic [31:0] b0;
        n   = eff_count(v);
        vec = v.va || v.vb;
        a0  = elem_a(v, 0);
        b0  = elem_b(v, 0);
        em  = (v.dex && !v.zero) ? v.dmask : 8'h00;
        for (int i = 0; i < n; i++) begin
            bit c;
            c = ref_cmp(v.op, v.va ? elem_a(v, i) : a0, v.vb ? elem_b(v, i) : b0);
            if (v.pred[i]) em[i] = c;
            else if (v.zero) em[i] = 1'b0;
        end
        if (vec) begin
            et = (em == v.pred);
            ew = v.dex;
        end else begin
            et = ref_cmp(v.op, a0, b0);
            em = 8'h00;
            ew = 1'b0;
        end

        @(negedge clk);
        apply_cfg(v);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // scramble configuration inputs: they must have been captured
        pred_i = ~v.pred; dst_mask_i = ~v.dmask; zeroing_i = ~v.zero;
        check(busy_o === 1'b1, "R10", "busy after start", 64'(busy_o), 64'd1);
        for (int i = 0; i < n; i++) begin
            if (v.gap && i > 0) begin
                elem_valid_i = 1'b0;
                @(negedge clk);
            end
            check(elem_idx_o === 3'(i), "R8", "element index", 64'(elem_idx_o), 64'(i));
            elem_valid_i = 1'b1;
            opa_i = elem_a(v, i);
            opb_i = elem_b(v, i);
            if (mode == 1 && i == 1) begin
                vl_i = 4'd1; src1_vec_i = 1'b1; start_i = 1'b1;
            end
            if (mode == 2 && i == n - 1) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        elem_valid_i = 1'b0;
        check(done_o === 1'b1, "R8 R9", "done after last element", 64'(done_o), 64'd1);
        check(taken_o === et, vec ? "R7" : "R1 R2", "taken", 64'(taken_o), 64'(et));
        check(mask_o === em, vec ? "R3 R4 R5 R6" : "R1", "mask", 64'(mask_o), 64'(em));
        check(mask_we_o === ew, vec ? "R7" : "R1", "write enable", 64'(mask_we_o), 64'(ew));
        @(negedge clk);
        check(done_o === 1'b0, "R9", "done is one cycle", 64'(done_o), 64'd0);
        check(busy_o === 1'b0, "R10", "no second request", 64'(busy_o), 64'd0);
        check(mask_we_o === 1'b0, "R9", "write enable outside pulse", 64'(mask_we_o), 64'd0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check(busy_o === 1'b0, "R11", "busy after reset", 64'(busy_o), 64'd0);
        check(done_o === 1'b0, "R11", "done after reset", 64'(done_o), 64'd0);
        check(taken_o === 1'b0, "R11", "taken after reset", 64'(taken_o), 64'd0);
        check(mask_o === 8'h00, "R11", "mask after reset", 64'(mask_o), 64'd0);
        check(mask_we_o === 1'b0, "R11", "we after reset", 64'(mask_we_o), 64'd0);

        // R10: operand strobes while idle do nothing
        elem_valid_i = 1'b1;
        opa_i = 32'd1;
        opb_i = 32'd1;
        repeat (3) @(negedge clk);
        elem_valid_i = 1'b0;
        check(done_o === 1'b0 && busy_o === 1'b0, "R10", "idle strobe ignored",
              64'({busy_o, done_o}), 64'd0);

        for (int k = 0; k < NVEC; k++) begin
            run_vec(VECS[k], 0);
        end

        // R10: restart attempt in the middle of a request
        run_vec(VECS[3], 1);
        // R10: start presented together with the final element
        run_vec(VECS[2], 2);
        run_vec(VECS[0], 2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule